// File: doc/BRIEF.md
# Split-Phase Programmable Clock Divider

This block divides an input clock by a ratio that is set through one 32-bit configuration word. The word holds two separate 6-bit counts. The high count sets how many input cycles the output stays high, and the low count sets how many it stays low, so the total ratio is their sum. Three control flags complete the word. The half-cycle flag extends the high phase by half an input cycle, which evens out the duty cycle of odd ratios. The pass-through flag forwards the input clock unchanged. The hold flag stores a written word without handing it to the running divider.

A written setting is kept as pending and only takes over at the end of the output period in progress, so a reconfiguration never cuts a phase short. Alongside the divided clock, the block drives a one-cycle period-end strobe in the input clock domain. It also contains a combinational encoder that turns an integer ratio and an apply request into a ready-to-write word, so software or a neighbouring sequencer never builds the fields by hand.

Top module: `clkdiv_hl_top`

## Requirements
- R1: After synchronous reset, the read-back word is 0x0000_2000 (pass-through), the output follows the input clock, and the strobe is high in every cycle.
- R2: Word fields are: low count in bits 5:0, high count in bits 11:6, half-cycle flag in bit 12, pass-through in bit 13, hold in bit 14. In divide mode each output period lasts high+low input cycles, high first and then low.
- R3: With the half-cycle flag set, the output falls half an input cycle late. Sampled just after rising input edges, it reads high for high+1 cycles per period. Sampled just after falling input edges, it reads high for high cycles.
- R4: With pass-through set, the output equals the input clock and the strobe is high every cycle, whatever the counts are.
- R5: A count field of zero, with pass-through clear, acts as a count of one.
- R6: A write with the hold bit (bit 14) set is stored for read-back but leaves the running ratio unchanged.
- R7: A write without the hold bit takes effect only after the output period in progress has run to its end with the old counts.
- R8: Read-back returns the last written word with bits 31:15 as zero.
- R9: The encoder puts floor(N/2) into the high field, ceil(N/2) into the low field and N mod 2 into bit 12. It sets bit 13 only for N=1 and sets bit 14 to the inverse of the apply request. All other bits are zero.
- R10: The strobe is high for exactly one input cycle per output period: the last cycle of the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Last written word, reserved bits zero |
| enc_ratio | input | 7 | Integer ratio for the encoder |
| enc_upd | input | 1 | Encoder apply request (0 sets the hold bit) |
| enc_word | output | 32 | Encoded configuration word |
| div_clk | output | 1 | Divided output clock |
| tick | output | 1 | One-cycle strobe on the last cycle of each output period |

## Verification
The hardest case to reach from the ports is a write that arrives in the middle of an output period. To show that the old period still finishes at full length, the write has to land at a known phase offset. The bench first waits for a strobe, then advances a fixed number of input cycles before issuing the write. It then counts the cycles to the next strobe and compares them with the old ratio, not the new one. The half-cycle extension can only be seen between edges, so the bench samples the output just after both rising and falling input edges and counts the high samples of each kind separately.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = 6;
    localparam int RATIO_W   = CNT_W + 1;
    localparam int LO_LSB    = 0;
    localparam int HI_LSB    = LO_LSB + CNT_W;
    localparam int HALF_BIT  = HI_LSB + CNT_W;
    localparam int PASS_BIT  = HALF_BIT + 1;
    localparam int HOLD_BIT  = PASS_BIT + 1;
    localparam int USED_W    = HOLD_BIT + 1;

    localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << PASS_BIT;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic pass;
        logic half;
        cnt_t hi;
        cnt_t lo;
    } div_cfg_t;

    function automatic div_cfg_t decode_word(logic [WORD_W-1:0] w);
        div_cfg_t d;
        d.lo   = w[LO_LSB +: CNT_W];
        d.hi   = w[HI_LSB +: CNT_W];
        d.half = w[HALF_BIT];
        d.pass = w[PASS_BIT];
        if (d.lo == '0) d.lo = cnt_t'(1);
        if (d.hi == '0) d.hi = cnt_t'(1);
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] encode_ratio(logic [RATIO_W-1:0] n, logic upd);
        logic [WORD_W-1:0]  w;
        logic [RATIO_W-1:0] h;
        logic [RATIO_W-1:0] l;
        h = n >> 1;
        l = n - h;
        w = '0;
        w[LO_LSB +: CNT_W] = l[CNT_W-1:0];
        w[HI_LSB +: CNT_W] = h[CNT_W-1:0];
        w[HALF_BIT]        = n[0];
        w[PASS_BIT]        = (n == RATIO_W'(1));
        w[HOLD_BIT]        = ~upd;
        return w;
    endfunction

endpackage

// File: rtl/clkdiv_ratio_enc.sv
module clkdiv_ratio_enc
    import clkdiv_pkg::*;
(
    input  logic [RATIO_W-1:0] ratio,
    input  logic               upd,
    output logic [WORD_W-1:0]  word
);

    localparam logic [RATIO_W-1:0] MAX_FIT = RATIO_W'(2 * ((1 << CNT_W) - 1));

    assign word = encode_ratio(ratio, upd);

    always_comb begin
        if (ratio <= MAX_FIT) begin
            AST_ENC_SUM: assert (RATIO_W'(word[HI_LSB +: CNT_W]) + RATIO_W'(word[LO_LSB +: CNT_W]) == ratio); // R9
        end
    end

endmodule

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              apply,
    output logic [WORD_W-1:0] rd_data,
    output div_cfg_t          act_cfg,
    output div_cfg_t          nxt_cfg
);

    logic [WORD_W-1:0] word_q;
    div_cfg_t          pend_q;
    logic              pend_v;
    div_cfg_t          act_q;
    logic              take;

    assign take    = apply && pend_v;
    assign nxt_cfg = take ? pend_q : act_q;
    assign act_cfg = act_q;
    assign rd_data = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= RESET_WORD;
            pend_q <= decode_word(RESET_WORD);
            pend_v <= 1'b0;
            act_q  <= decode_word(RESET_WORD);
        end else begin
            if (wr_en) begin
                word_q <= {{(WORD_W-USED_W){1'b0}}, wr_data[USED_W-1:0]};
            end
            if (take) begin
                act_q <= pend_q;
            end
            if (wr_en && !wr_data[HOLD_BIT]) begin
                pend_q <= decode_word(wr_data);
                pend_v <= 1'b1;
            end else if (take) begin
                pend_v <= 1'b0;
            end
        end
    end

    AST_HOLD_NO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[HOLD_BIT] && !apply) |=> ($stable(pend_v) && $stable(pend_q))); // R6

    AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(apply)); // R7

endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t act_cfg,
    input  div_cfg_t nxt_cfg,
    output logic     tick,
    output logic     div_clk
);

    logic phase_hi;
    cnt_t cnt;
    logic hi_late;

    assign tick = act_cfg.pass || (!phase_hi && cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_hi <= 1'b0;
            cnt      <= '0;
        end else if (tick) begin
            if (nxt_cfg.pass) begin
                phase_hi <= 1'b0;
                cnt      <= '0;
            end else begin
                phase_hi <= 1'b1;
                cnt      <= nxt_cfg.hi - 1'b1;
            end
        end else if (phase_hi && cnt == '0) begin
            phase_hi <= 1'b0;
            cnt      <= act_cfg.lo - 1'b1;
        end else begin
            cnt      <= cnt - 1'b1;
        end
    end

    // Falling-edge copy of the phase, used to stretch the high phase by half a cycle.
    always_ff @(negedge clk) begin
        if (rst) hi_late <= 1'b0;
        else     hi_late <= phase_hi;
    end

    assign div_clk = act_cfg.pass ? clk : (phase_hi | (act_cfg.half & hi_late));

    AST_HIGH_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!act_cfg.pass && phase_hi) |-> (cnt < act_cfg.hi)); // R2

    AST_LOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ($fell(phase_hi) && !act_cfg.pass) |-> (cnt == act_cfg.lo - 1'b1)); // R2

    AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_hi) |-> $past(tick)); // R10

endmodule

// File: rtl/clkdiv_hl_top.sv
module clkdiv_hl_top
    import clkdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [RATIO_W-1:0]   enc_ratio,
    input  logic                 enc_upd,
    output logic [WORD_W-1:0]    enc_word,
    output logic                 div_clk,
    output logic                 tick
);

    div_cfg_t act_cfg;
    div_cfg_t nxt_cfg;

    clkdiv_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .apply   (tick),
        .rd_data (rd_data),
        .act_cfg (act_cfg),
        .nxt_cfg (nxt_cfg)
    );

    clkdiv_phase_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .act_cfg (act_cfg),
        .nxt_cfg (nxt_cfg),
        .tick    (tick),
        .div_clk (div_clk)
    );

    clkdiv_ratio_enc u_enc (
        .ratio (enc_ratio),
        .upd   (enc_upd),
        .word  (enc_word)
    );

endmodule

// File: tb/sim_clkdiv_hl_top.sv
module sim_clkdiv_hl_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [6:0]  enc_ratio = '0;
    logic        enc_upd = 1'b0;
    logic [31:0] enc_word;
    logic        div_clk;
    logic        tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    clkdiv_hl_top u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .enc_ratio (enc_ratio),
        .enc_upd   (enc_upd),
        .enc_word  (enc_word),
        .div_clk   (div_clk),
        .tick      (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = w;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #2;
            if (tick) break;
        end
    endtask

    // Measures one whole output period, starting after a strobe.
    task automatic measure(output int per, output int hp, output int hn);
        per = 0; hp = 0; hn = 0;
        wait_tick();
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #2;
            per++;
            if (div_clk) hp++;
            @(negedge clk); #2;
            if (div_clk) hn++;
            if (tick) break;
        end
    endtask

    task automatic expect_period(input string req, input int ep, input int ehp, input int ehn);
        int p, hp, hn;
        measure(p, hp, hn);
        check(p == ep,   {req, " period"},      p,  ep);
        check(hp == ehp, {req, " high@rise"},   hp, ehp);
        check(hn == ehn, {req, " high@fall"},   hn, ehn);
    endtask

    task automatic t_reset();
        check(rd_data == 32'h0000_2000, "R1 reset word", rd_data, 32'h2000);
        expect_period("R1 reset pass-through", 1, 1, 0);
    endtask

    task automatic t_basic();
        write_word(32'h0000_00C5);          // hi=3 lo=5
        check(rd_data == 32'h0000_00C5, "R2 readback", rd_data, 32'hC5);
        expect_period("R2 R10 hi3 lo5", 8, 3, 3);
        write_word(32'h0000_0042);          // hi=1 lo=2
        expect_period("R2 R10 hi1 lo2", 3, 1, 1);
    endtask

    task automatic t_half();
        write_word(32'h0000_10C4);          // hi=3 lo=4 half
        expect_period("R3 half-cycle hi3 lo4", 7, 4, 3);
    endtask

    task automatic t_zero();
        write_word(32'h0000_0000);
        expect_period("R5 both zero", 2, 1, 1);
        write_word(32'h0000_00C0);          // hi=3 lo=0
        expect_period("R5 low zero", 4, 3, 3);
    endtask

    task automatic t_hold();
        write_word(32'h0000_4145);          // hold set, hi=5 lo=5
        check(rd_data == 32'h0000_4145, "R6 held word readback", rd_data, 32'h4145);
        expect_period("R6 ratio unchanged", 4, 3, 3);
        expect_period("R6 ratio still unchanged", 4, 3, 3);
    endtask

    task automatic t_stage();
        int k;
        write_word(32'h0000_00C5);          // period 8
        expect_period("R7 prior setting", 8, 3, 3);
        wait_tick();
        @(posedge clk); #2;                 // cycle 0 of period
        @(posedge clk); #2;                 // cycle 1
        wr_en = 1'b1; wr_data = 32'h0000_0042;
        @(posedge clk); #2;                 // cycle 2
        wr_en = 1'b0;
        k = 2;
        for (int i = 0; i < 300; i++) begin
            if (tick) break;
            @(posedge clk); #2;
            k++;
        end
        check(k == 7, "R7 old period completes", k, 7);
        expect_period("R7 new setting after end", 3, 1, 1);
    endtask

    task automatic t_reserved();
        write_word(32'hFFFF_80C5);
        check(rd_data == 32'h0000_00C5, "R8 reserved bits zero", rd_data, 32'hC5);
        expect_period("R8 reserved ignored", 8, 3, 3);
    endtask

    task automatic t_pass();
        write_word(32'h0000_2145);          // pass-through with counts 5/5
        expect_period("R4 pass-through", 1, 1, 0);
        expect_period("R4 pass-through again", 1, 1, 0);
        write_word(32'h0000_0145);
        expect_period("R4 leave pass-through", 10, 5, 5);
    endtask

    task automatic t_enc();
        enc_ratio = 7'd1;  enc_upd = 1'b0; #1;
        check(enc_word == 32'h0000_7001, "R9 N=1 hold", enc_word, 32'h7001);
        enc_ratio = 7'd1;  enc_upd = 1'b1; #1;
        check(enc_word == 32'h0000_3001, "R9 N=1 apply", enc_word, 32'h3001);
        enc_ratio = 7'd7;  enc_upd = 1'b1; #1;
        check(enc_word == 32'h0000_10C4, "R9 N=7", enc_word, 32'h10C4);
        enc_ratio = 7'd10; enc_upd = 1'b0; #1;
        check(enc_word == 32'h0000_4145, "R9 N=10 hold", enc_word, 32'h4145);
        enc_ratio = 7'd2;  enc_upd = 1'b1; #1;
        check(enc_word == 32'h0000_0041, "R9 N=2", enc_word, 32'h41);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_basic();
        t_half();
        t_zero();
        t_hold();
        t_stage();
        t_reserved();
        t_pass();
        t_enc();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule